// File: doc/BRIEF.md
# Multidrop Address Wake-Up Controller

This block sits between a UART deserializer and its receive FIFO and handles the nine-bit multidrop protocol. In that protocol the bit in the parity position is an address/data marker: 1 tags the character as an address and 0 tags it as data. For every completed character, the block decides whether the character is written to the FIFO. A FIFO write is also the event that raises the receiver-ready flag. The block also keeps the receiver-enable state, which decides whether data characters are accepted.

The parity-mode field turns the multidrop behaviour on. A two-bit sub-mode then picks one of four behaviours:
- **Host-controlled:** software enables and disables the receiver through command pulses.
- **Auto wake:** the receiver enables itself when it sees its own station address.
- **Auto doze:** the receiver disables itself when it sees any other address.
- **Wake plus doze:** both automatic actions apply.

In the automatic sub-modes, an address-load control decides whether address characters are written to the FIFO or dropped. When the parity-mode field holds any other value, the block passes characters through only while the receiver is enabled.

Top module: `mdrop_wake_ctrl`

## Requirements
- R1: While reset is asserted, and after reset, `rx_en` is 0 and `fifo_wr` is 0. Reset is asynchronous active-low, and its release takes effect two clock edges later.
- R2: When `par_mode` is not 2'b11, a character is stored exactly when `rx_en` is 1. The stored `fifo_perr` copies `char_perr`. A character never changes `rx_en` in this case.
- R3: With `par_mode`=2'b11, `wake_sel`=2'b00 and `rx_en`=0, an address character (`char_ad`=1) is stored and a data character (`char_ad`=0) is discarded. This also holds right after a receiver-reset command.
- R4: With `par_mode`=2'b11 and `rx_en`=1, every data character is stored. Every address character is also stored in `wake_sel`=2'b00.
- R5: With `par_mode`=2'b11, the stored `fifo_perr` equals the character's A/D bit, and `char_perr` is ignored.
- R6: The stored `fifo_ferr`, `fifo_ovr` and `fifo_brk` copy `char_ferr`, `char_ovr` and `char_brk` unchanged, whatever the value of `rx_en`.
- R7: With `wake_sel[0]`=1 (auto wake), an address character equal to `station_addr` on all 8 bits sets `rx_en`. A foreign address leaves `rx_en` unchanged when `wake_sel`=2'b01.
- R8: With `wake_sel[1]`=1 (auto doze), an address character that differs from `station_addr` clears `rx_en`. The own address leaves `rx_en` unchanged when `wake_sel`=2'b10.
- R9: With `wake_sel`=2'b11, the own address sets `rx_en` and a foreign address clears it.
- R10: With `wake_sel` not 2'b00, an address character is stored exactly when `addr_load`=1, whatever the value of `rx_en`.
- R11: With `wake_sel`=2'b00, characters never change `rx_en`.
- R12: `cmd_enable` sets `rx_en`, while `cmd_disable` or `cmd_rx_reset` clears it. A clearing command wins over `cmd_enable` and over an automatic change in the same cycle.
- R13: `fifo_wr` and the stored fields appear on the clock edge after `char_valid` is sampled, as a one-cycle pulse. A change of `rx_en` caused by that character appears on the same edge, so it governs the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 2 | Parity-mode field; 2'b11 selects multidrop |
| wake_sel | input | 2 | Sub-mode: bit 0 auto wake, bit 1 auto doze |
| addr_load | input | 1 | Store address characters in the automatic sub-modes |
| station_addr | input | 8 | Own station address |
| cmd_enable | input | 1 | Receiver enable command pulse |
| cmd_disable | input | 1 | Receiver disable command pulse |
| cmd_rx_reset | input | 1 | Receiver reset command pulse |
| char_valid | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Received data bits |
| char_ad | input | 1 | Bit in the parity position (A/D marker) |
| char_perr | input | 1 | Parity error of the character |
| char_ferr | input | 1 | Framing error of the character |
| char_ovr | input | 1 | Overrun flag |
| char_brk | input | 1 | Break flag |
| fifo_wr | output | 1 | FIFO write strobe; also sets receiver-ready |
| fifo_data | output | 8 | Data bits to store |
| fifo_perr | output | 1 | Parity-error status slot (A/D bit in multidrop) |
| fifo_ferr | output | 1 | Framing error to store |
| fifo_ovr | output | 1 | Overrun flag to store |
| fifo_brk | output | 1 | Break flag to store |
| rx_en | output | 1 | Receiver-enable state |

## Verification
The vectors walk each sub-mode through four cases: own address, foreign address, data with the receiver enabled, and data with it disabled. Comparing the own and foreign outcomes separates the wake action from the doze action. Comparing addr_load values separates address storage from the enable change. Non-multidrop characters with the parity-error input set show whether the A/D bit or the parity error reaches the status slot. Directed cases put a command in the same cycle as an address character and as an opposing command, and send flagged address characters after a receiver reset.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    SUB_HOST  = 2'b00,
    SUB_WAKE  = 2'b01,
    SUB_DOZE  = 2'b10,
    SUB_BOTH  = 2'b11
  } sub_mode_e;

  localparam logic [1:0] PAR_MULTIDROP = 2'b11;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic ovr;
    logic brk;
  } char_stat_t;
endpackage

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] char_data,
  input  logic [CHAR_W-1:0] station_addr,
  output logic              own_addr
);
  logic [CHAR_W-1:0] bit_eq;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
    assign bit_eq[i] = ~(char_data[i] ^ station_addr[i]);
  end

  assign own_addr = &bit_eq;
endmodule

// File: rtl/mdrop_store_decide.sv
module mdrop_store_decide
  import mdrop_pkg::*;
(
  input  logic       multidrop,
  input  logic [1:0] wake_sel,
  input  logic       addr_load,
  input  logic       rx_en,
  input  logic       char_valid,
  input  logic       char_ad,
  input  logic       char_perr,
  input  logic       char_ferr,
  input  logic       char_ovr,
  input  logic       char_brk,
  output logic       store,
  output char_stat_t stat_nx
);
  logic auto_mode;
  logic keep;

  always_comb begin
    auto_mode = (wake_sel != SUB_HOST);
    if (!multidrop) begin
      keep = rx_en;
    end else if (char_ad) begin
      keep = auto_mode ? addr_load : 1'b1;
    end else begin
      keep = rx_en;
    end
    store = char_valid & keep;

    stat_nx.perr = multidrop ? char_ad : char_perr;
    stat_nx.ferr = char_ferr;
    stat_nx.ovr  = char_ovr;
    stat_nx.brk  = char_brk;
  end
endmodule

// File: rtl/mdrop_enable_ctrl.sv
module mdrop_enable_ctrl
  import mdrop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n_int,
  input  logic       multidrop,
  input  logic [1:0] wake_sel,
  input  logic       char_valid,
  input  logic       char_ad,
  input  logic       own_addr,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       cmd_rx_reset,
  output logic       rx_en
);
  logic addr_evt;
  logic auto_set;
  logic auto_clr;
  logic en_nx;
  logic en_ce;

  always_comb begin
    addr_evt = multidrop & char_valid & char_ad;
    auto_set = addr_evt & wake_sel[0] &  own_addr;
    auto_clr = addr_evt & wake_sel[1] & ~own_addr;

    en_nx = rx_en;
    if (auto_set)                   en_nx = 1'b1;
    if (auto_clr)                   en_nx = 1'b0;
    if (cmd_enable)                 en_nx = 1'b1;
    if (cmd_disable | cmd_rx_reset) en_nx = 1'b0;

    en_ce = auto_set | auto_clr | cmd_enable | cmd_disable | cmd_rx_reset;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rx_en <= 1'b0;
    end else if (en_ce) begin
      rx_en <= en_nx;
    end
  end
endmodule

// File: rtl/mdrop_wake_ctrl.sv
module mdrop_wake_ctrl
  import mdrop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        par_mode,
  input  logic [1:0]        wake_sel,
  input  logic              addr_load,
  input  logic [CHAR_W-1:0] station_addr,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_rx_reset,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_ad,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              char_ovr,
  input  logic              char_brk,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_data,
  output logic              fifo_perr,
  output logic              fifo_ferr,
  output logic              fifo_ovr,
  output logic              fifo_brk,
  output logic              rx_en
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic                   multidrop;
  logic                   own_addr;
  logic                   store;
  char_stat_t             stat_nx;
  char_stat_t             stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  assign multidrop = (par_mode == PAR_MULTIDROP);

  mdrop_addr_match #(.CHAR_W(CHAR_W)) u_match (
    .char_data    (char_data),
    .station_addr (station_addr),
    .own_addr     (own_addr)
  );

  mdrop_store_decide u_decide (
    .multidrop  (multidrop),
    .wake_sel   (wake_sel),
    .addr_load  (addr_load),
    .rx_en      (rx_en),
    .char_valid (char_valid),
    .char_ad    (char_ad),
    .char_perr  (char_perr),
    .char_ferr  (char_ferr),
    .char_ovr   (char_ovr),
    .char_brk   (char_brk),
    .store      (store),
    .stat_nx    (stat_nx)
  );

  mdrop_enable_ctrl u_enable (
    .clk          (clk),
    .rst_n_int    (rst_n_int),
    .multidrop    (multidrop),
    .wake_sel     (wake_sel),
    .char_valid   (char_valid),
    .char_ad      (char_ad),
    .own_addr     (own_addr),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .cmd_rx_reset (cmd_rx_reset),
    .rx_en        (rx_en)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      fifo_wr <= 1'b0;
    end else begin
      fifo_wr <= store;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      fifo_data <= '0;
      stat_q    <= '0;
    end else if (store) begin
      fifo_data <= char_data;
      stat_q    <= stat_nx;
    end
  end

  assign fifo_perr = stat_q.perr;
  assign fifo_ferr = stat_q.ferr;
  assign fifo_ovr  = stat_q.ovr;
  assign fifo_brk  = stat_q.brk;
endmodule

// File: rtl/mdrop_wake_chk.sv
module mdrop_wake_chk (
  input logic       clk,
  input logic       rst_n_int,
  input logic [1:0] par_mode,
  input logic [1:0] wake_sel,
  input logic       addr_load,
  input logic [7:0] station_addr,
  input logic       cmd_enable,
  input logic       cmd_disable,
  input logic       cmd_rx_reset,
  input logic       char_valid,
  input logic [7:0] char_data,
  input logic       char_ad,
  input logic       fifo_wr,
  input logic       fifo_perr,
  input logic       rx_en
);
  logic md;
  logic no_cmd;
  assign md     = (par_mode == 2'b11);
  assign no_cmd = !cmd_enable && !cmd_disable && !cmd_rx_reset;

  // R13
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !char_valid |=> !fifo_wr);

  // R3
  host_data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (md && char_valid && !char_ad && !rx_en) |=> !fifo_wr);

  // R4
  enabled_data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (char_valid && !char_ad && rx_en) |=> fifo_wr);

  // R5
  ad_in_perr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (md && char_valid) |=> (!fifo_wr || fifo_perr == $past(char_ad)));

  // R7
  own_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (md && char_valid && char_ad && wake_sel[0] && char_data == station_addr
     && !cmd_disable && !cmd_rx_reset) |=> rx_en);

  // R8
  foreign_dozes_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (md && char_valid && char_ad && wake_sel[1] && char_data != station_addr
     && !cmd_enable) |=> !rx_en);

  // R10
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (md && char_valid && char_ad && wake_sel != 2'b00) |=> (fifo_wr == $past(addr_load)));

  // R11
  host_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wake_sel == 2'b00 && no_cmd) |=> $stable(rx_en));

  // R12
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_disable || cmd_rx_reset) |=> !rx_en);
endmodule

bind mdrop_wake_ctrl mdrop_wake_chk u_chk (
  .clk          (clk),
  .rst_n_int    (rst_n_int),
  .par_mode     (par_mode),
  .wake_sel     (wake_sel),
  .addr_load    (addr_load),
  .station_addr (station_addr),
  .cmd_enable   (cmd_enable),
  .cmd_disable  (cmd_disable),
  .cmd_rx_reset (cmd_rx_reset),
  .char_valid   (char_valid),
  .char_data    (char_data),
  .char_ad      (char_ad),
  .fifo_wr      (fifo_wr),
  .fifo_perr    (fifo_perr),
  .rx_en        (rx_en)
);

// File: tb/mdrop_wake_ctrl_tb.sv
module mdrop_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STATION = 8'h5A;

  typedef struct packed {
    logic [1:0] pm;
    logic [1:0] wm;
    logic       ld;
    logic       ce;
    logic       cd;
    logic       cv;
    logic [7:0] d;
    logic       ad;
    logic       fe;
    logic       pe;
    logic       ewr;
    logic       een;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 disabled drop
    '{2'b00,2'b00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R12 enable
    '{2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,8'h22,1'b0,1'b0,1'b1,1'b1,1'b1}, // R2 perr passes
    '{2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R12 disable
    '{2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,8'h33,1'b1,1'b0,1'b0,1'b1,1'b0}, // R3 R5 R11
    '{2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,8'h44,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 data drop
    '{2'b11,2'b00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R12
    '{2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,8'h55,1'b0,1'b1,1'b0,1'b1,1'b1}, // R4 R6
    '{2'b11,2'b00,1'b0,1'b0,1'b0,1'b1,8'h66,1'b1,1'b0,1'b0,1'b1,1'b1}, // R4 R11
    '{2'b11,2'b00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R12
    '{2'b11,2'b01,1'b0,1'b0,1'b0,1'b1,8'h66,1'b1,1'b0,1'b0,1'b0,1'b0}, // R7 R10
    '{2'b11,2'b01,1'b1,1'b0,1'b0,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b1,1'b1}, // R7 R10
    '{2'b11,2'b01,1'b0,1'b0,1'b0,1'b1,8'h77,1'b0,1'b0,1'b0,1'b1,1'b1}, // R13 next char
    '{2'b11,2'b01,1'b1,1'b0,1'b0,1'b1,8'h66,1'b1,1'b0,1'b0,1'b1,1'b1}, // R7 no doze
    '{2'b11,2'b10,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b0,1'b1}, // R8 own keeps
    '{2'b11,2'b10,1'b0,1'b0,1'b0,1'b1,8'h66,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 doze
    '{2'b11,2'b10,1'b0,1'b0,1'b0,1'b1,8'h88,1'b0,1'b0,1'b0,1'b0,1'b0}, // R13
    '{2'b11,2'b10,1'b1,1'b0,1'b0,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b1,1'b0}, // R10 R8
    '{2'b11,2'b11,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b0,1'b1}, // R9 wake
    '{2'b11,2'b11,1'b0,1'b0,1'b0,1'b1,8'h99,1'b0,1'b1,1'b1,1'b1,1'b1}, // R5 R6
    '{2'b11,2'b11,1'b1,1'b0,1'b0,1'b1,8'h66,1'b1,1'b0,1'b0,1'b1,1'b0}, // R9 doze
    '{2'b11,2'b11,1'b0,1'b0,1'b1,1'b1,8'h5A,1'b1,1'b0,1'b0,1'b0,1'b0}, // R12 priority
    '{2'b11,2'b01,1'b0,1'b0,1'b0,1'b1,8'hAA,1'b0,1'b0,1'b0,1'b0,1'b0}  // R13
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] par_mode, wake_sel;
  logic addr_load, cmd_enable, cmd_disable, cmd_rx_reset;
  logic char_valid, char_ad, char_perr, char_ferr, char_ovr, char_brk;
  logic [7:0] char_data;
  logic fifo_wr, fifo_perr, fifo_ferr, fifo_ovr, fifo_brk, rx_en;
  logic [7:0] fifo_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .wake_sel(wake_sel),
    .addr_load(addr_load), .station_addr(STATION), .cmd_enable(cmd_enable),
    .cmd_disable(cmd_disable), .cmd_rx_reset(cmd_rx_reset),
    .char_valid(char_valid), .char_data(char_data), .char_ad(char_ad),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_ovr(char_ovr),
    .char_brk(char_brk), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_perr(fifo_perr), .fifo_ferr(fifo_ferr), .fifo_ovr(fifo_ovr),
    .fifo_brk(fifo_brk), .rx_en(rx_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_enable = 0; cmd_disable = 0; cmd_rx_reset = 0;
    char_valid = 0; char_ad = 0; char_perr = 0; char_ferr = 0;
    char_ovr = 0; char_brk = 0; char_data = 8'h00; addr_load = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; par_mode = 2'b00; wake_sel = 2'b00;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 rx_en in reset", {7'd0, rx_en}, 8'd0);
    chk("R1 fifo_wr in reset", {7'd0, fifo_wr}, 8'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 rx_en after reset", {7'd0, rx_en}, 8'd0);

    for (int i = 0; i < NVEC; i++) begin
      par_mode = VECS[i].pm; wake_sel = VECS[i].wm; addr_load = VECS[i].ld;
      cmd_enable = VECS[i].ce; cmd_disable = VECS[i].cd; cmd_rx_reset = 0;
      char_valid = VECS[i].cv; char_data = VECS[i].d; char_ad = VECS[i].ad;
      char_ferr = VECS[i].fe; char_perr = VECS[i].pe; char_ovr = 0; char_brk = 0;
      @(negedge clk);
      chk($sformatf("R3/R4/R10/R13 store v%0d", i), {7'd0, fifo_wr}, {7'd0, VECS[i].ewr});
      chk($sformatf("R7/R8/R9/R11/R12 enable v%0d", i), {7'd0, rx_en}, {7'd0, VECS[i].een});
      if (VECS[i].ewr) begin
        chk($sformatf("R13 data v%0d", i), fifo_data, VECS[i].d);
        chk($sformatf("R2/R5 perr v%0d", i), {7'd0, fifo_perr},
            {7'd0, (VECS[i].pm == 2'b11) ? VECS[i].ad : VECS[i].pe});
        chk($sformatf("R6 ferr v%0d", i), {7'd0, fifo_ferr}, {7'd0, VECS[i].fe});
      end
    end
    idle_inputs();
    @(negedge clk);
    chk("R13 one-cycle strobe", {7'd0, fifo_wr}, 8'd0);

    // R12: enable and disable together -> disabled
    cmd_enable = 1; @(negedge clk); cmd_enable = 0;
    chk("R12 enable", {7'd0, rx_en}, 8'd1);
    cmd_enable = 1; cmd_disable = 1; @(negedge clk); idle_inputs();
    chk("R12 disable beats enable", {7'd0, rx_en}, 8'd0);

    // R3 after receiver reset, R6 flags with receiver disabled
    par_mode = 2'b11; wake_sel = 2'b00;
    cmd_enable = 1; @(negedge clk); idle_inputs();
    cmd_rx_reset = 1; @(negedge clk); idle_inputs();
    chk("R12 rx reset clears", {7'd0, rx_en}, 8'd0);
    char_valid = 1; char_ad = 1; char_data = 8'hC3; char_ovr = 1; char_brk = 1;
    @(negedge clk); idle_inputs();
    chk("R3 address after reset", {7'd0, fifo_wr}, 8'd1);
    chk("R3 address data", fifo_data, 8'hC3);
    chk("R6 overrun kept", {7'd0, fifo_ovr}, 8'd1);
    chk("R6 break kept", {7'd0, fifo_brk}, 8'd1);

    // R2: characters in non-multidrop mode leave rx_en alone
    par_mode = 2'b01; wake_sel = 2'b11;
    char_valid = 1; char_ad = 1; char_data = STATION;
    @(negedge clk); idle_inputs();
    chk("R2 no wake outside multidrop", {7'd0, rx_en}, 8'd0);
    chk("R2 no store when disabled", {7'd0, fifo_wr}, 8'd0);

    // R1: asynchronous reset while enabled
    cmd_enable = 1; @(negedge clk); idle_inputs();
    #(CLK_PERIOD/4) rst_n = 0; #1;
    chk("R1 async clear", {7'd0, rx_en}, 8'd0);
    @(negedge clk); rst_n = 1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule